// File: doc/BRIEF.md
# Block Decoder Command and Status Unit

This unit sits at the register edge of a block-transform decoder. Software writes 32-bit words to a single write port. When the unit is idle, a written word is a command: the top three bits pick the operation, a nibble of output-format flags is latched, and a count of parameter words is loaded. While a command is still collecting parameters, every write is passed on as a parameter word. The downstream datapath consumes each parameter word and pulses a strobe, which counts the remaining parameters down.

A 32-bit status word is always available on the read port. It reports the FIFO flags, the busy state, the two DMA request lines, a mirror of the latched format flags, the block currently being handled and the number of parameter words still expected, minus one.

Control is a three-state machine:
- **ST_IDLE** accepts commands.
- **ST_COLLECT** counts parameter words.
- **ST_FINISH** waits for the datapath to report completion.

The transitions are:
- IDLE to COLLECT on a command with a nonzero count.
- COLLECT to FINISH on the last consumed parameter.
- COLLECT to IDLE when the last parameter and the done pulse arrive together.
- FINISH to IDLE on the done pulse.

Top module: `blkdec_cmd_ctrl`

## Requirements
- R1: After reset the status word reads 0x0004FFFF when all inputs are low: not busy, format flags zero, block field 4, count field 0xFFFF.
- R2: A command with op 1 (bits 31..29) loads its parameter count from bits 15..0, and the status count field (bits 15..0) reads that count minus one.
- R3: Ops 2 and 3 load a count of 64 whatever bits 15..0 hold, so the status count field reads 63.
- R4: The color-table output takes command bit 0 for op 2 and is 1 for every other op.
- R5: For every op, command bits 28..25 are latched and appear in status bits 26..23, and bits 31..29 appear on the op output.
- R6: A command with a nonzero count sets busy (status bit 29); a command with a zero count leaves busy clear and the count field at 0xFFFF.
- R7: Each consume strobe while collecting lowers the count by one; the field reads 0xFFFF once no words remain.
- R8: Busy stays set after the last word is consumed until the done input is high; a done input together with the last consume clears busy in the same cycle.
- R9: A write while busy raises the parameter-valid output with the written word, and it leaves the op, the format flags and the count unchanged.
- R10: Status bit 28 is high exactly when input DMA is enabled, the input FIFO is not full and busy is set.
- R11: Status bit 27 is high exactly when output DMA is enabled and the output FIFO is not empty.
- R12: Status bit 31 mirrors output-FIFO-empty, bit 30 mirrors input-FIFO-full, and bits 22..19 are zero.
- R13: Status bits 18..16 carry the current-block input when the latched depth is 2 or 3. When the depth is 0 or 1 (monochrome) they read 4.
- R14: A consume strobe while idle has no effect: the count field stays 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the command/parameter port |
| wr_data | input | 32 | Written word |
| param_take | input | 1 | Datapath has consumed one parameter word |
| proc_done | input | 1 | Datapath has finished the current command |
| ofifo_empty | input | 1 | Output FIFO empty |
| ififo_full | input | 1 | Input FIFO full |
| dma_in_en | input | 1 | Input DMA channel enabled |
| dma_out_en | input | 1 | Output DMA channel enabled |
| cur_block | input | 3 | Block index in process (0..3 luma, 4 Cr, 5 Cb) |
| status_o | output | 32 | Status read data |
| cmd_op | output | 3 | Latched operation code |
| color_tbl | output | 1 | Latched color-table flag |
| out_depth | output | 2 | Latched output depth |
| out_signed | output | 1 | Latched signed-output flag |
| out_bit15 | output | 1 | Latched set-bit-15 flag |
| param_valid | output | 1 | Current write is a parameter word |
| param_data | output | 32 | Parameter word, valid with param_valid |

## Verification
The assertions assume that the datapath pulses the consume strobe only for words it has actually taken. They also assume that the done pulse arrives no earlier than the last consume. Apart from that, consume and done pulses that come at other times are treated as having no effect.

The stimulus honours this. Each command is followed by exactly as many consume pulses as its count, and then by a done pulse, which is either separate from the last consume or on the same cycle. Stray consume pulses are issued only while the unit is idle, which is the case covered by R14.

The sweeps cover all ops, depths and flags, all sixteen combinations of the FIFO and DMA inputs, and every block index.

// File: rtl/blkdec_pkg.sv
package blkdec_pkg;

    localparam int WORD_W   = 32;
    localparam int CNT_W    = 16;
    localparam int BLK_W    = 3;
    localparam int OP_W     = 3;

    // field positions in the command word
    localparam int OP_LSB   = 29;
    localparam int FMT_LSB  = 25;
    localparam int FMT_W    = 4;

    localparam logic [OP_W-1:0] OP_DECODE = 3'd1;
    localparam logic [OP_W-1:0] OP_QTAB   = 3'd2;
    localparam logic [OP_W-1:0] OP_STAB   = 3'd3;

    localparam logic [BLK_W-1:0] MONO_BLK = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_FINISH  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [1:0] depth;
        logic       sgn;
        logic       hi_bit;
    } fmt_t;

endpackage

// File: rtl/blkdec_cmd_parse.sv
module blkdec_cmd_parse
    import blkdec_pkg::*;
#(
    parameter int TABLE_WORDS = 64
) (
    input  logic [OP_W-1:0]  op_bits,
    input  logic [FMT_W-1:0] fmt_bits,
    input  logic [CNT_W-1:0] cnt_bits,
    input  logic             bit0,
    output fmt_t             fmt,
    output logic             color,
    output logic [CNT_W-1:0] count,
    output logic             count_nz
);
    localparam logic [CNT_W-1:0] TABLE_CNT = CNT_W'(TABLE_WORDS);

    logic is_table;

    always_comb begin
        is_table = (op_bits == OP_QTAB) || (op_bits == OP_STAB);
        fmt      = fmt_t'(fmt_bits);
        color    = (op_bits == OP_QTAB) ? bit0 : 1'b1;
        count    = is_table ? TABLE_CNT : cnt_bits;
        count_nz = (count != '0);
    end

endmodule

// File: rtl/blkdec_param_cnt.sv
module blkdec_param_cnt
    import blkdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] rem,
    output logic             last
);
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign rem  = rem_q;
    assign last = (rem_q == CNT_W'(1));

    // R7: without a load the remaining count never grows
    p_rem_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> rem_q <= $past(rem_q));

endmodule

// File: rtl/blkdec_status_pack.sv
module blkdec_status_pack
    import blkdec_pkg::*;
(
    input  logic             ofifo_empty,
    input  logic             ififo_full,
    input  logic             busy,
    input  logic             dma_in_en,
    input  logic             dma_out_en,
    input  fmt_t             fmt,
    input  logic [BLK_W-1:0] cur_block,
    input  logic [CNT_W-1:0] rem,
    output logic [WORD_W-1:0] status
);
    localparam int PAD_W = WORD_W - 5 - FMT_W - BLK_W - CNT_W;

    logic             din_req;
    logic             dout_req;
    logic [BLK_W-1:0] blk;

    always_comb begin
        din_req  = dma_in_en && !ififo_full && busy;
        dout_req = dma_out_en && !ofifo_empty;
        blk      = (fmt.depth < 2'd2) ? MONO_BLK : cur_block;
        status   = {ofifo_empty, ififo_full, busy, din_req, dout_req,
                    fmt, {PAD_W{1'b0}}, blk, rem - 1'b1};
    end

endmodule

// File: rtl/blkdec_cmd_ctrl.sv
module blkdec_cmd_ctrl
    import blkdec_pkg::*;
#(
    parameter int TABLE_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              param_take,
    input  logic              proc_done,
    input  logic              ofifo_empty,
    input  logic              ififo_full,
    input  logic              dma_in_en,
    input  logic              dma_out_en,
    input  logic [2:0]        cur_block,
    output logic [31:0]       status_o,
    output logic [2:0]        cmd_op,
    output logic              color_tbl,
    output logic [1:0]        out_depth,
    output logic              out_signed,
    output logic              out_bit15,
    output logic              param_valid,
    output logic [31:0]       param_data
);
    ctl_state_e st_q, st_nx;

    logic             busy, cmd_accept, take_eff;
    fmt_t             p_fmt, fmt_q;
    logic             p_color, color_q;
    logic [CNT_W-1:0] p_count, rem;
    logic             p_count_nz, last;
    logic [OP_W-1:0]  op_q;

    blkdec_cmd_parse #(.TABLE_WORDS(TABLE_WORDS)) u_parse (
        .op_bits  (wr_data[OP_LSB +: OP_W]),
        .fmt_bits (wr_data[FMT_LSB +: FMT_W]),
        .cnt_bits (wr_data[CNT_W-1:0]),
        .bit0     (wr_data[0]),
        .fmt      (p_fmt),
        .color    (p_color),
        .count    (p_count),
        .count_nz (p_count_nz)
    );

    blkdec_param_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_accept),
        .load_val (p_count),
        .dec      (take_eff),
        .rem      (rem),
        .last     (last)
    );

    blkdec_status_pack u_stat (
        .ofifo_empty (ofifo_empty),
        .ififo_full  (ififo_full),
        .busy        (busy),
        .dma_in_en   (dma_in_en),
        .dma_out_en  (dma_out_en),
        .fmt         (fmt_q),
        .cur_block   (cur_block),
        .rem         (rem),
        .status      (status_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:    if (cmd_accept && p_count_nz) st_nx = ST_COLLECT;
            ST_COLLECT: if (take_eff && last)
                            st_nx = proc_done ? ST_IDLE : ST_FINISH;
            ST_FINISH:  if (proc_done) st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        busy        = (st_q != ST_IDLE);
        cmd_accept  = wr_en && !busy;
        param_valid = wr_en && busy;
        take_eff    = param_take && (st_q == ST_COLLECT);
    end

    // command field latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            fmt_q   <= '0;
            color_q <= 1'b1;
        end else if (cmd_accept) begin
            op_q    <= wr_data[OP_LSB +: OP_W];
            fmt_q   <= p_fmt;
            color_q <= p_color;
        end
    end

    assign param_data = wr_data;
    assign cmd_op     = op_q;
    assign color_tbl  = color_q;
    assign out_depth  = fmt_q.depth;
    assign out_signed = fmt_q.sgn;
    assign out_bit15  = fmt_q.hi_bit;

    // R6: busy only rises after an accepted command
    p_busy_from_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[29]) |-> $past(cmd_accept));
    // R8: busy only falls with the done input
    p_clear_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[29]) |-> $past(proc_done));
    // R9: format flags hold while a command is in flight
    p_fmt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fmt_q) && $stable(op_q));
    // R3: table loads always expect 64 words
    p_tab_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && (wr_data[31:29] == OP_QTAB || wr_data[31:29] == OP_STAB))
        |=> status_o[15:0] == 16'(TABLE_WORDS - 1));
    // R7: idle always reports no outstanding words
    p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> status_o[15:0] == 16'hFFFF);
    // R10: input request implies busy and room in the FIFO
    p_din_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[28] |-> status_o[29] && !ififo_full);
    // R13: monochrome depths report the fixed block index
    p_blk_mono_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_depth < 2'd2) |-> status_o[18:16] == MONO_BLK);

endmodule

// File: tb/blkdec_cmd_ctrl_bench.sv
module blkdec_cmd_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        param_take = 1'b0, proc_done = 1'b0;
    logic        ofifo_empty = 1'b0, ififo_full = 1'b0;
    logic        dma_in_en = 1'b0, dma_out_en = 1'b0;
    logic [2:0]  cur_block = '0;
    logic [31:0] status_o, param_data;
    logic [2:0]  cmd_op;
    logic        color_tbl, out_signed, out_bit15, param_valid;
    logic [1:0]  out_depth;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    logic        m_busy = 1'b0;
    logic [15:0] m_rem  = '0;
    logic [3:0]  m_fmt  = '0;

    always #2 clk = ~clk;

    blkdec_cmd_ctrl u_blkdec_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .param_take(param_take), .proc_done(proc_done),
        .ofifo_empty(ofifo_empty), .ififo_full(ififo_full),
        .dma_in_en(dma_in_en), .dma_out_en(dma_out_en),
        .cur_block(cur_block), .status_o(status_o), .cmd_op(cmd_op),
        .color_tbl(color_tbl), .out_depth(out_depth), .out_signed(out_signed),
        .out_bit15(out_bit15), .param_valid(param_valid), .param_data(param_data)
    );

    function automatic logic [31:0] exp_status();
        logic [2:0] blk;
        blk = (m_fmt[3:2] < 2) ? 3'd4 : cur_block;
        return {ofifo_empty, ififo_full, m_busy, dma_in_en & ~ififo_full & m_busy,
                dma_out_en & ~ofifo_empty, m_fmt, 4'b0, blk, m_rem - 16'd1};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a command while idle; sits at a negedge afterwards
    task automatic send_cmd(input logic [31:0] w);
        logic [2:0] op;
        op = w[31:29];
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        m_fmt  = w[28:25];
        m_rem  = (op == 3'd2 || op == 3'd3) ? 16'd64 : w[15:0];
        m_busy = (m_rem != 0);
        #1;
    endtask

    task automatic take_one(input logic with_done);
        param_take = 1'b1; proc_done = with_done;
        @(negedge clk);
        param_take = 1'b0; proc_done = 1'b0;
        if (m_rem != 0) m_rem = m_rem - 1;
        if (with_done && m_rem == 0) m_busy = 1'b0;
        #1;
    endtask

    task automatic finish_cmd();
        proc_done = 1'b1;
        @(negedge clk);
        proc_done = 1'b0;
        m_busy = 1'b0;
        #1;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset status", status_o, 32'h0004FFFF);
        check("R4 reset color", {31'b0, color_tbl}, 32'd1);

        // R2 R3 R4 R5 R6 R7 R8: sweep ops, depths and flags
        for (int op = 0; op < 8; op++) begin
            for (int f = 0; f < 16; f++) begin
                logic [31:0] w;
                logic [2:0]  o3;
                logic [3:0]  f4;
                o3 = 3'(op);
                f4 = 4'(f);
                w = {o3, f4, 9'b0, 15'd1, f4[2]};
                send_cmd(w);
                check("R5 status", status_o, exp_status());
                check("R5 op", {29'b0, cmd_op}, {29'b0, o3});
                check("R4 color", {31'b0, color_tbl},
                      {31'b0, (o3 == 3'd2) ? f4[2] : 1'b1});
                check("R2 R3 count", {16'b0, status_o[15:0]},
                      {16'b0, ((o3 == 3'd2 || o3 == 3'd3) ? 16'd63 : 16'(2 + f4[2] - 1))});
                take_one(1'b0);
                check("R7 after one take", status_o, exp_status());
                while (m_rem != 0) take_one(1'b0);
                check("R8 still busy", status_o, exp_status());
                finish_cmd();
                check("R8 cleared", status_o, exp_status());
            end
        end

        // R6: zero count
        send_cmd({3'd1, 4'b1110, 9'b0, 16'd0});
        check("R6 zero count", status_o, exp_status());
        check("R6 zero count idle", {31'b0, status_o[29]}, 32'd0);

        // R14: stray consume when idle
        take_one(1'b0);
        check("R14 idle take", {16'b0, status_o[15:0]}, 32'h0000FFFF);

        // R9 and R8 simultaneous
        send_cmd({3'd1, 4'b1010, 9'b0, 16'd5});
        wr_en = 1'b1; wr_data = 32'h6000_0007;
        #1;
        check("R9 param valid", {31'b0, param_valid}, 32'd1);
        check("R9 param data", param_data, 32'h6000_0007);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R9 op unchanged", {29'b0, cmd_op}, 32'd1);
        check("R9 status unchanged", status_o, exp_status());
        check("R9 count unchanged", {16'b0, status_o[15:0]}, 32'd4);

        // R10 R11 R12 sweep while busy
        for (int c = 0; c < 16; c++) begin
            {ofifo_empty, ififo_full, dma_in_en, dma_out_en} = 4'(c);
            #1;
            check("R10 R11 R12 busy", status_o, exp_status());
        end
        while (m_rem > 1) take_one(1'b0);
        take_one(1'b1);
        check("R8 done with last", status_o, exp_status());
        check("R8 idle", {31'b0, status_o[29]}, 32'd0);
        for (int c = 0; c < 16; c++) begin
            {ofifo_empty, ififo_full, dma_in_en, dma_out_en} = 4'(c);
            #1;
            check("R10 R11 R12 idle", status_o, exp_status());
        end
        {ofifo_empty, ififo_full, dma_in_en, dma_out_en} = 4'b0;

        // R13: current block
        send_cmd({3'd1, 4'b1000, 9'b0, 16'd0});
        for (int b = 0; b < 8; b++) begin
            cur_block = 3'(b);
            #1;
            check("R13 color block", {29'b0, status_o[18:16]}, b);
        end
        send_cmd({3'd1, 4'b0100, 9'b0, 16'd0});
        for (int b = 0; b < 8; b++) begin
            cur_block = 3'(b);
            #1;
            check("R13 mono block", {29'b0, status_o[18:16]}, 32'd4);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule